// File: doc/BRIEF.md
# ADC Self-Test Step Scheduler

This block sits between a conversion trigger unit and an analog-to-digital converter. Each scheduled command word carries a 2-bit mode field and a 2-bit algorithm field. Ordinary conversion commands are passed on as a one-cycle conversion pulse. Self-test commands become a series of step triggers. Each trigger carries a family code and a step index, and the next trigger waits until the converter reports that the current step is done.

There are three self-test families. The short family S has three steps and always runs atomically. The two longer families, RC and C, have step counts set by parameters. A configuration input chooses how they run. In burst mode one command runs all of RC and then all of C. In interleaved mode each command runs a single step, picked by a counter that keeps its value between commands. The FULL algorithm chains S, RC and C into one atomic burst. The block marks when user conversions must be held off, and it ignores commands while a sequence is in progress.

Top module: `adc_selftest_sched`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `user_block`, `st_trig` and `conv_trig` are low after that edge, and the interleave counter returns to RC step 0.
- R2: A command accepted while idle with mode 00, 10 or 11 gives one `conv_trig` pulse in the cycle after it is accepted, with no step trigger. `conv_dual` is 0 for mode 00 and 1 for modes 10 and 11.
- R3: Mode 01 with algorithm 00 issues steps S0, S1, S2 in that order, whatever `cfg_interleave` is set to. Family code 00 on `st_fam` means S.
- R4: Mode 01 with algorithm 01 or 10 and `cfg_interleave`=0 issues RC steps 0 to RC_STEPS-1, then C steps 0 to C_STEPS-1. Family code 01 means RC and 10 means C.
- R5: Mode 01 with algorithm 11 issues S0..S2, then the full RC sequence, then the full C sequence, whatever `cfg_interleave` is set to.
- R6: Mode 01 with algorithm 01 or 10 and `cfg_interleave`=1 issues exactly one step, taken from a counter. The counter moves through RC 0..RC_STEPS-1 and then C 0..C_STEPS-1, wraps back to RC 0, and keeps its value between commands.
- R7: Each `st_trig` is a one-cycle pulse, and `st_fam`/`st_step` hold their values between pulses. A `step_done` that is high in a trigger's own cycle is ignored. The next trigger comes in the cycle after `step_done` is sampled high.
- R8: `user_block` is high in every trigger cycle of an S, FULL or burst sequence, and low during a single interleaved step. It falls after the final `step_done`.
- R9: `busy` is high from the first trigger until the final `step_done` is sampled. Any command presented while `busy` is high is ignored.
- R10: The first step trigger and the rise of `busy` both appear in the cycle after a self-test command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Scheduled command present |
| cmd_mode | input | 2 | Mode field: 00 single, 01 self-test, 10/11 dual |
| cmd_alg | input | 2 | Algorithm field: 00 S, 01 RC, 10 C, 11 FULL |
| cfg_interleave | input | 1 | 1 selects one-step-per-command for RC/C |
| step_done | input | 1 | Converter finished the current step |
| st_trig | output | 1 | One-cycle self-test step trigger |
| st_fam | output | 2 | Family of current step: 00 S, 01 RC, 10 C |
| st_step | output | STEP_W | Step index within the family |
| conv_trig | output | 1 | One-cycle ordinary conversion trigger |
| conv_dual | output | 1 | Conversion is dual |
| user_block | output | 1 | User conversions must be held off |
| busy | output | 1 | Sequence in progress, commands refused |

## Verification
Some properties are checked on every cycle: triggers are single-cycle pulses, a trigger and `user_block` appear only while `busy` is high, conversion pulses never overlap a sequence, the step index stays fixed between triggers, and the first trigger comes together with the rise of `busy`. The order of steps across S, RC and C, the interleave counter's progress and wrap, its return to RC step 0 on reset, and the refusal of commands sent mid-sequence can only be shown by the bench. It compares whole trigger traces against a model built from the requirements.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic [1:0] {
    FAM_S  = 2'b00,
    FAM_RC = 2'b01,
    FAM_C  = 2'b10
  } fam_e;

  typedef enum logic [2:0] {
    K_CONV,
    K_S,
    K_FULL,
    K_BURST,
    K_INTLV
  } kind_e;

  localparam logic [1:0] MODE_SELFTEST = 2'b01;
  localparam logic [1:0] ALG_S         = 2'b00;
  localparam logic [1:0] ALG_FULL      = 2'b11;
endpackage

// File: rtl/ast_cmd_decode.sv
module ast_cmd_decode
  import ast_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] alg_i,
  input  logic       ilv_i,
  output kind_e      kind_o,
  output logic       dual_o
);
  always_comb begin
    dual_o = mode_i[1];
    if (mode_i != MODE_SELFTEST) begin
      kind_o = K_CONV;
    end else if (alg_i == ALG_S) begin
      kind_o = K_S;
    end else if (alg_i == ALG_FULL) begin
      kind_o = K_FULL;
    end else begin
      kind_o = ilv_i ? K_INTLV : K_BURST;
    end
  end
endmodule

// File: rtl/ast_phase_step.sv
module ast_phase_step
  import ast_pkg::*;
#(
  parameter int RC_STEPS = 4,
  parameter int C_STEPS  = 3,
  parameter int STEP_W   = 2
) (
  input  fam_e              fam_i,
  input  logic [STEP_W-1:0] step_i,
  output fam_e              fam_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] S_LAST  = STEP_W'(2);
  localparam logic [STEP_W-1:0] RC_LAST = STEP_W'(RC_STEPS - 1);
  localparam logic [STEP_W-1:0] C_LAST  = STEP_W'(C_STEPS - 1);

  always_comb begin
    fam_o  = fam_i;
    step_o = step_i + STEP_W'(1);
    case (fam_i)
      FAM_S: if (step_i == S_LAST) begin
        fam_o  = FAM_RC;
        step_o = '0;
      end
      FAM_RC: if (step_i == RC_LAST) begin
        fam_o  = FAM_C;
        step_o = '0;
      end
      default: if (step_i == C_LAST) begin
        fam_o  = FAM_RC;
        step_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/ast_intlv_cnt.sv
module ast_intlv_cnt
  import ast_pkg::*;
#(
  parameter int RC_STEPS = 4,
  parameter int C_STEPS  = 3,
  parameter int STEP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output fam_e              fam_o,
  output logic [STEP_W-1:0] step_o
);
  fam_e              nfam;
  logic [STEP_W-1:0] nstep;

  ast_phase_step #(
    .RC_STEPS(RC_STEPS),
    .C_STEPS (C_STEPS),
    .STEP_W  (STEP_W)
  ) succ_i (
    .fam_i (fam_o),
    .step_i(step_o),
    .fam_o (nfam),
    .step_o(nstep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fam_o  <= FAM_RC;
      step_o <= '0;
    end else if (adv_i) begin
      fam_o  <= nfam;
      step_o <= nstep;
    end
  end
endmodule

// File: rtl/adc_selftest_sched.sv
module adc_selftest_sched
  import ast_pkg::*;
#(
  parameter int RC_STEPS = 4,
  parameter int C_STEPS  = 3,
  localparam int LONGEST = (RC_STEPS > C_STEPS) ? RC_STEPS : C_STEPS,
  localparam int MAXS    = (LONGEST > 3) ? LONGEST : 3,
  localparam int STEP_W  = $clog2(MAXS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic [1:0]        cmd_alg,
  input  logic              cfg_interleave,
  input  logic              step_done,
  output logic              st_trig,
  output logic [1:0]        st_fam,
  output logic [STEP_W-1:0] st_step,
  output logic              conv_trig,
  output logic              conv_dual,
  output logic              user_block,
  output logic              busy
);
  localparam logic [STEP_W-1:0] S_LAST = STEP_W'(2);
  localparam logic [STEP_W-1:0] C_LAST = STEP_W'(C_STEPS - 1);

  kind_e             kind;
  logic              dual;
  logic              accept;
  logic              take_done;
  logic              last_step;
  logic              atomic;
  fam_e              cur_fam, end_fam, nxt_fam, cnt_fam;
  fam_e              start_fam, stop_fam;
  logic [STEP_W-1:0] cur_step, end_step, nxt_step, cnt_step;
  logic [STEP_W-1:0] start_step, stop_step;

  ast_cmd_decode dec_i (
    .mode_i(cmd_mode),
    .alg_i (cmd_alg),
    .ilv_i (cfg_interleave),
    .kind_o(kind),
    .dual_o(dual)
  );

  ast_intlv_cnt #(
    .RC_STEPS(RC_STEPS),
    .C_STEPS (C_STEPS),
    .STEP_W  (STEP_W)
  ) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .adv_i (accept && (kind == K_INTLV)),
    .fam_o (cnt_fam),
    .step_o(cnt_step)
  );

  ast_phase_step #(
    .RC_STEPS(RC_STEPS),
    .C_STEPS (C_STEPS),
    .STEP_W  (STEP_W)
  ) seq_succ_i (
    .fam_i (cur_fam),
    .step_i(cur_step),
    .fam_o (nxt_fam),
    .step_o(nxt_step)
  );

  assign accept    = cmd_valid && !busy;
  assign take_done = busy && !st_trig && step_done;
  assign last_step = (cur_fam == end_fam) && (cur_step == end_step);
  assign atomic    = (kind != K_INTLV);

  // Start and end phase of the sequence a command asks for
  always_comb begin
    start_fam  = FAM_S;
    start_step = '0;
    stop_fam   = FAM_C;
    stop_step  = C_LAST;
    case (kind)
      K_S: begin
        stop_fam  = FAM_S;
        stop_step = S_LAST;
      end
      K_BURST: start_fam = FAM_RC;
      K_INTLV: begin
        start_fam  = cnt_fam;
        start_step = cnt_step;
        stop_fam   = cnt_fam;
        stop_step  = cnt_step;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_trig    <= 1'b0;
      conv_trig  <= 1'b0;
      conv_dual  <= 1'b0;
      user_block <= 1'b0;
      busy       <= 1'b0;
      cur_fam    <= FAM_S;
      cur_step   <= '0;
      end_fam    <= FAM_S;
      end_step   <= '0;
    end else begin
      st_trig   <= 1'b0;
      conv_trig <= 1'b0;
      if (accept) begin
        if (kind == K_CONV) begin
          conv_trig <= 1'b1;
          conv_dual <= dual;
        end else begin
          busy       <= 1'b1;
          user_block <= atomic;
          st_trig    <= 1'b1;
          cur_fam    <= start_fam;
          cur_step   <= start_step;
          end_fam    <= stop_fam;
          end_step   <= stop_step;
        end
      end else if (take_done) begin
        if (last_step) begin
          busy       <= 1'b0;
          user_block <= 1'b0;
        end else begin
          cur_fam  <= nxt_fam;
          cur_step <= nxt_step;
          st_trig  <= 1'b1;
        end
      end
    end
  end

  assign st_fam  = cur_fam;
  assign st_step = cur_step;
endmodule

// File: rtl/ast_sched_chk.sv
module ast_sched_chk #(
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              st_trig,
  input logic [1:0]        st_fam,
  input logic [STEP_W-1:0] st_step,
  input logic              conv_trig,
  input logic              user_block,
  input logic              busy
);
  // R7
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    st_trig |=> !st_trig);

  // R9
  trig_busy_chk: assert property (@(posedge clk) disable iff (rst)
    st_trig |-> busy);

  // R8
  block_busy_chk: assert property (@(posedge clk) disable iff (rst)
    user_block |-> busy);

  // R2
  conv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    conv_trig |-> (!busy && !st_trig));

  // R10
  first_trig_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> st_trig);

  // R7
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_trig |-> ($stable(st_step) && $stable(st_fam)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !st_trig && !user_block && !conv_trig));
endmodule

bind adc_selftest_sched ast_sched_chk #(.STEP_W(STEP_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .st_trig   (st_trig),
  .st_fam    (st_fam),
  .st_step   (st_step),
  .conv_trig (conv_trig),
  .user_block(user_block),
  .busy      (busy)
);

// File: tb/adc_selftest_sched_tb.sv
module adc_selftest_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RC_N = 4;
  localparam int C_N  = 3;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] alg;
    logic       ilv;
    logic [3:0] cnt;
    logic       blk;
    logic       conv;
    logic       dual;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b00, 1'b0, 4'd3,  1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b00, 1'b1, 4'd3,  1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b01, 1'b0, 4'd7,  1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b10, 1'b0, 4'd7,  1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b11, 1'b0, 4'd10, 1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b11, 1'b1, 4'd10, 1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b01, 1'b1, 4'd1,  1'b0, 1'b0, 1'b0},
    '{2'b01, 2'b10, 1'b1, 4'd1,  1'b0, 1'b0, 1'b0},
    '{2'b00, 2'b01, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0},
    '{2'b10, 2'b00, 1'b1, 4'd0,  1'b0, 1'b1, 1'b1},
    '{2'b11, 2'b11, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic [1:0] cmd_alg = 2'b00;
  logic       cfg_interleave = 1'b0;
  logic       step_done = 1'b0;
  logic       st_trig;
  logic [1:0] st_fam;
  logic [1:0] st_step;
  logic       conv_trig;
  logic       conv_dual;
  logic       user_block;
  logic       busy;

  int n_checks = 0;
  int n_errs   = 0;

  // bench model of the interleave counter
  int m_fam  = 1;
  int m_step = 0;

  // expected and observed traces
  int ef [16];
  int es [16];
  int en;
  int tf [16];
  int ts [16];
  int tblk [16];
  int tn;
  int conv_seen;
  int conv_d;
  int adj;
  int first_trig;
  int conv_at_poke;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_selftest_sched #(.RC_STEPS(RC_N), .C_STEPS(C_N)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_mode      (cmd_mode),
    .cmd_alg       (cmd_alg),
    .cfg_interleave(cfg_interleave),
    .step_done     (step_done),
    .st_trig       (st_trig),
    .st_fam        (st_fam),
    .st_step       (st_step),
    .conv_trig     (conv_trig),
    .conv_dual     (conv_dual),
    .user_block    (user_block),
    .busy          (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int f, input int s);
    if (en < 16) begin
      ef[en] = f;
      es[en] = s;
    end
    en++;
  endtask

  task automatic build_exp(input logic [1:0] mode, input logic [1:0] alg, input bit ilv);
    en = 0;
    if (mode != 2'b01) return;
    if (alg == 2'b00 || alg == 2'b11)
      for (int i = 0; i < 3; i++) push(0, i);
    if (alg == 2'b11 || !ilv) begin
      if (alg != 2'b00) begin
        for (int i = 0; i < RC_N; i++) push(1, i);
        for (int i = 0; i < C_N; i++) push(2, i);
      end
    end else if (alg != 2'b00) begin
      push(m_fam, m_step);
      if (m_fam == 1 && m_step == RC_N - 1) begin m_fam = 2; m_step = 0; end
      else if (m_fam == 2 && m_step == C_N - 1) begin m_fam = 1; m_step = 0; end
      else m_step++;
    end
  endtask

  task automatic run_cmd(input logic [1:0] mode, input logic [1:0] alg, input bit ilv,
                         input bit hold_done, input bit poke);
    int prev;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_mode = mode;
    cmd_alg = alg;
    cfg_interleave = ilv;
    step_done = hold_done;
    @(negedge clk);
    cmd_valid = 1'b0;
    tn = 0; prev = 0; adj = 0; conv_seen = 0; conv_d = 0; first_trig = 0;
    conv_at_poke = 0;
    for (int c = 0; c < 200; c++) begin
      if (conv_trig) begin conv_seen++; conv_d = conv_dual; end
      if (c == 0) first_trig = st_trig;
      if (st_trig) begin
        if (prev != 0) adj = 1;
        if (tn < 16) begin
          tf[tn] = st_fam;
          ts[tn] = st_step;
          tblk[tn] = user_block;
        end
        tn++;
      end
      if (!busy && !st_trig) break;
      step_done = hold_done ? 1'b1 : prev[0];
      if (poke && c == 1) begin
        cmd_valid = 1'b1;
        cmd_mode = 2'b00;
      end else begin
        cmd_valid = 1'b0;
      end
      prev = st_trig;
      @(negedge clk);
    end
    step_done = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic verify_trace(input string req, input int exp_blk);
    int bad;
    check(tn == en, req, "step count", tn, en);
    bad = -1;
    for (int i = 0; i < tn && i < en && i < 16; i++)
      if (bad < 0 && (tf[i] != ef[i] || ts[i] != es[i])) bad = i;
    if (bad >= 0)
      check(1'b0, req, "step fam*16+idx", tf[bad]*16 + ts[bad], ef[bad]*16 + es[bad]);
    else
      check(1'b1, req, "step order", 0, 0);
    bad = 0;
    for (int i = 0; i < tn && i < 16; i++) if (tblk[i] != exp_blk) bad++;
    check(bad == 0, "R8", "user_block in trigger cycles mismatches", bad, 0);
    check(adj == 0, "R7", "back-to-back trigger", adj, 0);
    check(!busy && !user_block, "R9", "busy/block after last done", {busy, user_block}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_fam = 1;
    m_step = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    string req;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check({busy, user_block, st_trig, conv_trig} == 4'b0, "R1", "outputs in reset",
          {busy, user_block, st_trig, conv_trig}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].mode != 2'b01) req = "R2";
      else if (VECS[v].alg == 2'b00) req = "R3";
      else if (VECS[v].alg == 2'b11) req = "R5";
      else if (VECS[v].ilv) req = "R6";
      else req = "R4";
      build_exp(VECS[v].mode, VECS[v].alg, VECS[v].ilv);
      run_cmd(VECS[v].mode, VECS[v].alg, VECS[v].ilv, 1'b0, 1'b0);
      check(en == VECS[v].cnt, req, "model vs table count", en, VECS[v].cnt);
      verify_trace(req, VECS[v].blk);
      check(conv_seen == VECS[v].conv, "R2", "conv pulses", conv_seen, VECS[v].conv);
      if (VECS[v].conv) check(conv_d == VECS[v].dual, "R2", "conv_dual", conv_d, VECS[v].dual);
      if (VECS[v].cnt != 0) check(first_trig == 1, "R10", "first trigger cycle", first_trig, 1);
    end

    // R6: interleave counter walks remaining steps and wraps to RC 0
    for (int k = 0; k < RC_N + C_N; k++) begin
      build_exp(2'b01, 2'b01, 1'b1);
      run_cmd(2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
      verify_trace("R6", 0);
    end

    // R7: done held high, trigger-cycle done ignored, every step still issued
    build_exp(2'b01, 2'b11, 1'b0);
    run_cmd(2'b01, 2'b11, 1'b0, 1'b1, 1'b0);
    verify_trace("R7", 1);

    // R9: conversion command during a sequence is ignored
    build_exp(2'b01, 2'b00, 1'b0);
    run_cmd(2'b01, 2'b00, 1'b0, 1'b0, 1'b1);
    verify_trace("R9", 1);
    check(conv_seen == 0, "R9", "conv pulse while busy", conv_seen, 0);

    // R1: reset returns interleave counter to RC 0
    build_exp(2'b01, 2'b10, 1'b1);
    run_cmd(2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
    build_exp(2'b01, 2'b10, 1'b1);
    run_cmd(2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
    do_reset();
    build_exp(2'b01, 2'b10, 1'b1);
    check(ef[0] == 1 && es[0] == 0, "R1", "model restart", ef[0]*16 + es[0], 16);
    run_cmd(2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
    verify_trace("R1", 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule